// File: doc/BRIEF.md
# Floating-Point Register Stack with Occupancy Tags

This block holds eight 64-bit floating-point registers arranged as a circular stack. A 3-bit pointer marks the current top. Each register also carries a tag bit that says whether it holds a value. Operations reach the registers relative to the top: entry i from the top, called ST(i), lives in physical slot (top + i) mod 8. The pointer can wrap freely in both directions.

Operations arrive on a single-cycle strobe port. Each one carries an opcode, a relative index, write data and two exemption qualifiers. The block pushes, pops, reads, writes, or reads and rewrites an entry in place. Each operation is checked against the tags. Touching an empty entry by read or modify raises an empty fault. Overwriting a full entry by a plain write or a push raises a full fault. One qualifier marks an examine-style read, which may look at an empty entry without faulting. The other marks a copy from ST(0), which may land on a full entry without faulting. A faulting operation changes nothing. Read data and fault flags are registered and appear one cycle after the strobe.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset the top pointer is 0, every tag is empty, both fault outputs are 0 and the read data is 0.
- R2: A push (opcode 1) first moves the top to (top-1) mod 8, then writes the data into the slot at the new top and marks that slot full.
- R3: A pop (opcode 2) returns the value in the slot at the current top, clears that slot's tag, and moves the top to (top+1) mod 8.
- R4: Read (opcode 3), write (opcode 4) and modify (opcode 5) address physical slot (top + index) mod 8, and the pointer wraps in both directions.
- R5: A pop, a read, or a modify that targets an empty slot raises the empty fault.
- R6: A push onto a full slot raises the full fault. A write onto a full slot also raises it.
- R7: A read with the examine qualifier set never raises the empty fault and still returns the stored value. The qualifier has no effect on other opcodes.
- R8: A write with the ST(0)-copy qualifier set never raises the full fault and still stores its data. The qualifier has no effect on other opcodes.
- R9: A faulting operation leaves all registers, all tags and the top pointer unchanged.
- R10: The fault outputs are registered and valid in the cycle after the strobe. They are never both high, and they return to 0 after a cycle with no faulting operation.
- R11: A modify returns the old value of the slot as read data and stores the new data in that same operation.
- R12: Opcodes 0, 6 and 7, and any cycle with the strobe low, change no state and raise no fault. Read data updates only on pop, read and modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_code | input | 3 | 0 none, 1 push, 2 pop, 3 read, 4 write, 5 modify, 6/7 none |
| op_idx | input | 3 | Relative index i of ST(i) |
| op_wdata | input | 64 | Data for push, write and modify |
| op_examine | input | 1 | Examine-style read: empty fault suppressed |
| op_st0_copy | input | 1 | Copy from ST(0): full fault suppressed on write |
| rd_data | output | 64 | Value read by the last pop, read or modify |
| flt_empty | output | 1 | Register-empty fault of the previous cycle's operation |
| flt_full | output | 1 | Register-full fault of the previous cycle's operation |
| top_ptr | output | 3 | Current top-of-stack physical index |

## Verification
Two functions share a clock edge in this block. On a push, the pointer decrement and the data write happen together. On a modify, the read of the old value and the write of the new value happen together. In both cases the write must land on the slot chosen in the same cycle, and the read must not see the new value. The bench drives push and modify back to back with wrapping pointers, then reads ST(0) or checks the returned old value. A reference model updates its pointer and its array in the same order the requirements state, and the bench compares against it.

// File: rtl/fpstk_pkg.sv
// Package for the floating-point register stack.
// Holds the opcode encoding that the port op_code carries.
package fpstk_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PUSH   = 3'd1,
        OP_POP    = 3'd2,
        OP_READ   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_MODIFY = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } fpstk_op_e;

endpackage

// File: rtl/fpstk_addr.sv
// Slot address generator.
// Maps an operation to the physical slot it touches. A push targets
// (top-1) mod DEPTH and a pop targets top. All other opcodes target
// (top+idx) mod DEPTH. Assumes DEPTH is a power of two, so the
// modulo is plain truncation.
module fpstk_addr
    import fpstk_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  fpstk_op_e        op,
    input  logic [PTR_W-1:0] top,
    input  logic [PTR_W-1:0] idx,
    output logic [PTR_W-1:0] slot
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    // Choose the physical slot for this operation.
    always_comb begin
        case (op)
            OP_PUSH: slot = top - ONE;
            OP_POP:  slot = top;
            default: slot = top + idx;
        endcase
    end

endmodule

// File: rtl/fpstk_fault.sv
// Fault decision and commit control.
// From the opcode, the target slot's tag and the two exemption
// qualifiers, this module decides which fault the operation raises
// and which state updates it may commit. A faulting operation commits
// nothing. Purely combinational.
module fpstk_fault
    import fpstk_pkg::*;
(
    input  logic      valid,
    input  fpstk_op_e op,
    input  logic      tag_full,
    input  logic      examine,
    input  logic      st0_copy,
    output logic      empty_flt,
    output logic      full_flt,
    output logic      do_read,
    output logic      do_write,
    output logic      set_tag,
    output logic      clr_tag,
    output logic      top_inc,
    output logic      top_dec
);

    // Apply the tag rules and the exemptions, then gate the commits.
    always_comb begin
        empty_flt = 1'b0;
        full_flt  = 1'b0;
        do_read   = 1'b0;
        do_write  = 1'b0;
        set_tag   = 1'b0;
        clr_tag   = 1'b0;
        top_inc   = 1'b0;
        top_dec   = 1'b0;
        if (valid) begin
            case (op)
                OP_PUSH: begin
                    full_flt = tag_full;
                    do_write = !tag_full;
                    set_tag  = !tag_full;
                    top_dec  = !tag_full;
                end
                OP_POP: begin
                    do_read   = 1'b1;
                    empty_flt = !tag_full;
                    clr_tag   = tag_full;
                    top_inc   = tag_full;
                end
                OP_READ: begin
                    do_read   = 1'b1;
                    empty_flt = !tag_full && !examine;
                end
                OP_WRITE: begin
                    full_flt = tag_full && !st0_copy;
                    do_write = !full_flt;
                    set_tag  = !full_flt;
                end
                OP_MODIFY: begin
                    do_read   = 1'b1;
                    empty_flt = !tag_full;
                    do_write  = tag_full;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/fpstk_regfile.sv
// Register array with per-slot occupancy tags.
// DEPTH words of DATA_W bits share one access index. A write and a
// tag change land on that slot at the clock edge. The read port is
// combinational and returns the slot's value from before that edge.
// Synchronous active-low reset clears all data and tags.
module fpstk_regfile #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_tag,
    input  logic              clr_tag,
    output logic [DATA_W-1:0] rd_word,
    output logic [DEPTH-1:0]  tag_vec
);

    logic [DEPTH-1:0][DATA_W-1:0] word_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DATA_W-1:0] word_q;
        logic              tag_q;
        logic              hit;

        assign hit = (idx == PTR_W'(g));

        // Hold one slot's data and tag, updating on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
                tag_q  <= 1'b0;
            end else begin
                if (wr_en && hit) begin
                    word_q <= wr_data;
                end
                if (set_tag && hit) begin
                    tag_q <= 1'b1;
                end else if (clr_tag && hit) begin
                    tag_q <= 1'b0;
                end
            end
        end

        assign word_vec[g] = word_q;
        assign tag_vec[g]  = tag_q;
    end

    assign rd_word = word_vec[idx];

endmodule

// File: rtl/fp_reg_stack.sv
// Floating-point register stack, top level.
// Eight circular slots with a top pointer and occupancy tags. Accepts
// one operation per strobe. Read data, fault flags and the pointer are
// registered, so each operation's result shows one cycle after its
// strobe. Assumes DEPTH is a power of two.
module fp_reg_stack
    import fpstk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [PTR_W-1:0]  op_idx,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic              op_examine,
    input  logic              op_st0_copy,
    output logic [DATA_W-1:0] rd_data,
    output logic              flt_empty,
    output logic              flt_full,
    output logic [PTR_W-1:0]  top_ptr
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    fpstk_op_e         op;
    logic [PTR_W-1:0]  top_q;
    logic [PTR_W-1:0]  slot;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rd_q;
    logic [DEPTH-1:0]  tag_vec;
    logic              empty_flt, full_flt;
    logic              empty_q, full_q;
    logic              do_read, do_write, set_tag, clr_tag;
    logic              top_inc, top_dec;

    assign op = fpstk_op_e'(op_code);

    fpstk_addr #(.PTR_W(PTR_W)) u_addr (
        .op   (op),
        .top  (top_q),
        .idx  (op_idx),
        .slot (slot)
    );

    fpstk_fault u_fault (
        .valid     (op_valid),
        .op        (op),
        .tag_full  (tag_vec[slot]),
        .examine   (op_examine),
        .st0_copy  (op_st0_copy),
        .empty_flt (empty_flt),
        .full_flt  (full_flt),
        .do_read   (do_read),
        .do_write  (do_write),
        .set_tag   (set_tag),
        .clr_tag   (clr_tag),
        .top_inc   (top_inc),
        .top_dec   (top_dec)
    );

    fpstk_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (slot),
        .wr_en   (do_write),
        .wr_data (op_wdata),
        .set_tag (set_tag),
        .clr_tag (clr_tag),
        .rd_word (rd_word),
        .tag_vec (tag_vec)
    );

    // Move the top pointer on a committed push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else if (top_dec) begin
            top_q <= top_q - ONE;
        end else if (top_inc) begin
            top_q <= top_q + ONE;
        end
    end

    // Capture read data and this cycle's fault decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= '0;
            empty_q <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            if (do_read) begin
                rd_q <= rd_word;
            end
            empty_q <= empty_flt;
            full_q  <= full_flt;
        end
    end

    assign rd_data   = rd_q;
    assign flt_empty = empty_q;
    assign flt_full  = full_q;
    assign top_ptr   = top_q;

endmodule

// File: rtl/fpstk_checker.sv
// Assertion checker for fp_reg_stack, bound to every instance.
// Observes the ports and the tag vector from the register array.
module fpstk_checker
    import fpstk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [PTR_W-1:0] op_idx,
    input logic             op_examine,
    input logic             op_st0_copy,
    input logic             flt_empty,
    input logic             flt_full,
    input logic [PTR_W-1:0] top_ptr,
    input logic [DEPTH-1:0] tag_vec
);

    logic [PTR_W-1:0] below_top;
    logic [PTR_W-1:0] rel_slot;
    logic             started_q = 1'b0;
    logic             rst_prev_q = 1'b1;

    assign below_top = top_ptr - PTR_W'(1);
    assign rel_slot  = top_ptr + op_idx;

    // Track the previous reset level for the reset-state check.
    always_ff @(posedge clk) begin
        started_q  <= 1'b1;
        rst_prev_q <= rst_n;
    end

    // R1: one cycle after reset is applied, pointer and faults are clear.
    always_ff @(posedge clk) begin
        if (started_q && !rst_prev_q) begin
            p_reset_state_r1: assert (top_ptr == '0 && !flt_empty && !flt_full && tag_vec == '0);
        end
    end

    p_push_moves_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_PUSH && !tag_vec[below_top]) |=> (top_ptr == $past(below_top)));

    p_pop_moves_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_POP && tag_vec[top_ptr]) |=> (top_ptr == $past(top_ptr) + PTR_W'(1)));

    p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_READ && !tag_vec[rel_slot] && !op_examine) |=> flt_empty);

    p_full_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_WRITE && tag_vec[rel_slot] && !op_st0_copy) |=> flt_full);

    p_examine_exempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_READ && op_examine) |=> !flt_empty);

    p_copy_exempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_WRITE && op_st0_copy) |=> !flt_full);

    p_fault_holds_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_empty || flt_full) |-> $stable(top_ptr));

    p_faults_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(flt_empty && flt_full));

    p_idle_no_fault_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid) |=> (!flt_empty && !flt_full && $stable(top_ptr)));

endmodule

bind fp_reg_stack fpstk_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_fpstk_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .op_idx      (op_idx),
    .op_examine  (op_examine),
    .op_st0_copy (op_st0_copy),
    .flt_empty   (flt_empty),
    .flt_full    (flt_full),
    .top_ptr     (top_ptr),
    .tag_vec     (tag_vec)
);

// File: tb/fp_reg_stack_bench.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random
// operations, each compared with a reference model of the requirements.
module fp_reg_stack_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [2:0]  op_idx = 3'd0;
    logic [63:0] op_wdata = '0;
    logic        op_examine = 1'b0;
    logic        op_st0_copy = 1'b0;
    logic [63:0] rd_data;
    logic        flt_empty, flt_full;
    logic [2:0]  top_ptr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [63:0] m_reg [8];
    logic        m_tag [8];
    logic [2:0]  m_top;
    logic [63:0] e_rd;
    logic        e_fe, e_ff;

    always #10 clk = ~clk;

    fp_reg_stack u_fp_reg_stack (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_idx(op_idx), .op_wdata(op_wdata), .op_examine(op_examine),
        .op_st0_copy(op_st0_copy), .rd_data(rd_data), .flt_empty(flt_empty),
        .flt_full(flt_full), .top_ptr(top_ptr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 8; k++) begin
            m_reg[k] = '0;
            m_tag[k] = 1'b0;
        end
        m_top = 3'd0; e_rd = '0; e_fe = 1'b0; e_ff = 1'b0;
    endtask

    // Model the requirement rules for one operation.
    task automatic model_op(input logic [2:0] c, input logic [2:0] i, input logic [63:0] d,
                            input bit ex, input bit cp);
        logic [2:0] s;
        e_fe = 1'b0; e_ff = 1'b0;
        case (c)
            3'd1: begin // R2 push
                s = m_top - 3'd1;
                if (m_tag[s]) e_ff = 1'b1;
                else begin m_top = s; m_reg[s] = d; m_tag[s] = 1'b1; end
            end
            3'd2: begin // R3 pop
                s = m_top; e_rd = m_reg[s];
                if (!m_tag[s]) e_fe = 1'b1;
                else begin m_tag[s] = 1'b0; m_top = m_top + 3'd1; end
            end
            3'd3: begin // R4 read, R7 examine
                s = m_top + i; e_rd = m_reg[s];
                e_fe = !m_tag[s] && !ex;
            end
            3'd4: begin // R4 write, R8 copy
                s = m_top + i;
                if (m_tag[s] && !cp) e_ff = 1'b1;
                else begin m_reg[s] = d; m_tag[s] = 1'b1; end
            end
            3'd5: begin // R11 modify
                s = m_top + i; e_rd = m_reg[s];
                if (!m_tag[s]) e_fe = 1'b1;
                else m_reg[s] = d;
            end
            default: begin end
        endcase
    endtask

    function automatic string req_of(input logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R4";
            3'd5: return "R11";
            default: return "R12";
        endcase
    endfunction

    // Drive one operation at a negedge, then check at the next negedge.
    task automatic do_op(input logic [2:0] c, input logic [2:0] i, input logic [63:0] d,
                         input bit ex, input bit cp);
        string r;
        op_valid = 1'b1; op_code = c; op_idx = i; op_wdata = d;
        op_examine = ex; op_st0_copy = cp;
        model_op(c, i, d, ex, cp);
        r = req_of(c);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk(top_ptr == m_top, {r, " top"}, 64'(top_ptr), 64'(m_top));
        chk(rd_data == e_rd, {r, " rd_data"}, rd_data, e_rd);
        chk(flt_empty == e_fe, "R5 flt_empty", 64'(flt_empty), 64'(e_fe));
        chk(flt_full == e_ff, "R6 flt_full", 64'(flt_full), 64'(e_ff));
        if (e_fe || e_ff) chk(top_ptr == m_top, "R9 fault holds top", 64'(top_ptr), 64'(m_top));
    endtask

    task automatic idle_check();
        @(posedge clk);
        @(negedge clk);
        e_fe = 1'b0; e_ff = 1'b0;
        chk(!flt_empty && !flt_full, "R10 faults clear after idle",
            64'({flt_empty, flt_full}), 64'd0);
        chk(top_ptr == m_top, "R12 idle holds top", 64'(top_ptr), 64'(m_top));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(top_ptr == 3'd0, "R1 top", 64'(top_ptr), 64'd0);
        chk(!flt_empty && !flt_full, "R1 faults", 64'({flt_empty, flt_full}), 64'd0);
        chk(rd_data == '0, "R1 rd_data", rd_data, 64'd0);
        // R1: every tag empty, seen as an empty fault on each read
        for (int k = 0; k < 8; k++) do_op(3'd3, 3'(k), '0, 1'b0, 1'b0);
        // R7: examine of an empty slot, no fault
        do_op(3'd3, 3'd2, '0, 1'b1, 1'b0);
        // R2 push wraps top to 7, then R4 read ST(0) sees it
        do_op(3'd1, 3'd0, 64'hA5A5_0000_0000_0001, 1'b0, 1'b0);
        do_op(3'd3, 3'd0, '0, 1'b0, 1'b0);
        // R11 modify returns the old value, the next read returns the new one
        do_op(3'd5, 3'd0, 64'h1111_2222_3333_4444, 1'b0, 1'b0);
        do_op(3'd3, 3'd0, '0, 1'b0, 1'b0);
        // Fill all eight slots, then a ninth push faults (R6, R9)
        for (int k = 0; k < 7; k++) do_op(3'd1, 3'd0, 64'(k) << 8, 1'b0, 1'b0);
        do_op(3'd1, 3'd0, 64'hDEAD, 1'b0, 1'b0);
        idle_check();
        // R6 plain write to full faults; R8 copy exemption stores
        do_op(3'd4, 3'd3, 64'hBEEF, 1'b0, 1'b0);
        do_op(3'd4, 3'd3, 64'hCAFE, 1'b0, 1'b1);
        do_op(3'd3, 3'd3, '0, 1'b0, 1'b0);
        // R12 reserved opcodes and stray qualifiers have no effect
        do_op(3'd6, 3'd1, 64'h77, 1'b1, 1'b1);
        do_op(3'd7, 3'd2, 64'h78, 1'b1, 1'b1);
        do_op(3'd0, 3'd3, 64'h79, 1'b0, 1'b1);
        // R3 pop everything, then one more pop underflows (R5)
        for (int k = 0; k < 9; k++) do_op(3'd2, 3'd0, '0, 1'b1, 1'b1);
        idle_check();
        // R5 modify of an empty slot faults and keeps data (R9)
        do_op(3'd5, 3'd4, 64'h55, 1'b0, 1'b0);
        do_op(3'd3, 3'd4, '0, 1'b1, 1'b0);
        // Random mix, pushes and pops weighted up
        for (int n = 0; n < 1500; n++) begin
            logic [2:0] c;
            int w;
            w = int'($urandom_range(0, 9));
            c = (w >= 8) ? 3'(w - 7) : 3'(w);
            do_op(c, 3'($urandom_range(0, 7)), {$urandom, $urandom},
                  ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 15) == 0) idle_check();
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule